// File: doc/BRIEF.md
# Data-Strobe Link Character Transmitter

The block serialises link characters onto a two-wire data-strobe pair, one bit per clock. At every character boundary it picks what to send next from four sources: a pending time code, a pending flow-control token (FCT), a data or end-of-packet entry taken from a transmit FIFO, and the idle filler NULL. Data characters are 10 bits and control characters are 4 bits. The block computes the parity of each character and shifts it out. The data line carries the bit value, and the strobe line toggles on every bit where the data line holds its level.

The block keeps a credit count for outgoing data. The receive side of the link signals each FCT that arrives from the far end over a four-phase request/acknowledge pair from another clock domain. Each such FCT adds a fixed number of credits. Each data or end-of-packet character sent costs one credit. An FCT that would push the count past its ceiling raises a sticky credit error and adds nothing. One FIFO entry is prefetched into a holding register, so the next data character is ready when the current character ends.

The controller has two states. ST_IDLE means nothing is being shifted. ST_SEND means a character is leaving the shift register. The transition ST_IDLE→ST_SEND happens when a source is picked. ST_SEND→ST_SEND happens on each bit, and at the last bit of a character when another source is picked. ST_SEND→ST_IDLE happens at the last bit when no source is ready.

Top module: `ds_char_tx`

## Requirements
- R1: While reset is held and just after it is released, d_out, s_out, credit_err and fct_ack are all 0.
- R2: Each clock in which a bit is sent, exactly one of d_out and s_out changes, and d_out takes the bit value. Characters follow each other with no idle clock between them, so a steady NULL stream changes the line on every clock.
- R3: Every character is sent as parity bit, then flag bit, then payload with the least significant bit first. A data character has flag 0 and 8 payload bits. A control character has flag 1 and a 2-bit code: FCT=0, EOP=1, EEP=2, ESC=3.
- R4: Each parity bit makes the count of ones odd over the payload bits of the previous character plus the current parity and flag bits. Before the first character after reset, the previous payload is taken as all zeros.
- R5: With en_null high and no other source ready, NULLs are sent. A NULL is ESC immediately followed by FCT.
- R6: A tick_in pulse latches time_in and flags_in. The latched time code is sent as ESC followed by a data character whose payload bits 5:0 carry the time value and bits 7:6 carry the flags. The time code waits while en_time is low.
- R7: A fct_send pulse queues one FCT character, which is sent as soon as en_fct is high.
- R8: At a character boundary the choice is made in this order: time code, then FCT, then FIFO entry, then NULL.
- R9: FIFO entries are sent in FIFO order, only while en_data is high and the credit count is nonzero. Each one sent costs one credit. An entry with bit 8 = 0 is sent as a data character of bits 7:0. An entry with bit 8 = 1 is sent as EOP if bit 0 is 0 and as EEP if bit 0 is 1.
- R10: fct_ack follows fct_req with a two-clock delay. Each rising edge of fct_req adds 8 credits.
- R11: If an FCT arrives while the credit count is above 48, so that the count would exceed 56, credit_err goes to 1 and stays there. The count does not change.
- R12: With every enable low and nothing in progress, d_out and s_out hold their levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| en_null | input | 1 | Permit NULL filler |
| en_fct | input | 1 | Permit sending queued FCTs |
| en_data | input | 1 | Permit sending FIFO entries |
| en_time | input | 1 | Permit sending the latched time code |
| fifo_empty | input | 1 | Transmit FIFO has no entry |
| fifo_dout | input | 9 | Head FIFO entry (bit 8 = end-of-packet marker) |
| fifo_rd | output | 1 | Pop the head FIFO entry into the holding register |
| tick_in | input | 1 | Time-code request pulse |
| time_in | input | 6 | Time value captured on tick_in |
| flags_in | input | 2 | Control flags captured on tick_in |
| fct_send | input | 1 | Queue one outgoing FCT |
| fct_req | input | 1 | FCT-received request from the receive domain |
| fct_ack | output | 1 | Acknowledge of fct_req |
| d_out | output | 1 | Data line |
| s_out | output | 1 | Strobe line |
| credit_err | output | 1 | Sticky credit-overflow flag |

## Verification
A time-code request, an FCT request and a fresh FIFO entry are raised in the same clock while NULLs stream out and credit is available. The bench then decodes the line and expects, in this order, exactly one time code, one lone FCT and one data character. The second collision is between a received FCT and the credit ceiling. Eight FCTs are acknowledged in a row with data sending disabled. credit_err must stay low after the seventh and go high after the eighth. Data sending is then enabled, and exactly 56 data characters must leave the block, which shows that the rejected credits were never added.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

    typedef enum logic [1:0] {
        CC_FCT = 2'd0,
        CC_EOP = 2'd1,
        CC_EEP = 2'd2,
        CC_ESC = 2'd3
    } ctrl_code_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_t;

    typedef enum logic [2:0] {
        PICK_NONE,
        PICK_TIME,
        PICK_FCT,
        PICK_DATA,
        PICK_NULL
    } pick_t;

    localparam int CTRL_LEN = 4;
    localparam int DATA_LEN = 10;

    // control character, bit 0 leaves first: parity, flag=1, code lsb, code msb
    function automatic logic [3:0] ctrl_char(input logic prev_x, input ctrl_code_t code);
        logic [1:0] c;
        c = code;
        return {c[1], c[0], 1'b1, prev_x};
    endfunction

    // data character, bit 0 leaves first: parity, flag=0, payload lsb..msb
    function automatic logic [9:0] data_char(input logic prev_x, input logic [7:0] val);
        return {val, 1'b0, ~prev_x};
    endfunction

endpackage

// File: rtl/ds_fct_sync.sv
module ds_fct_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic ack,
    output logic evt
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= req_async;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign ack = s2_q;
    assign evt = s2_q & ~s3_q;

    // R10: acknowledge rises only after the request was seen two clocks earlier
    a_r10_ack_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req_async, 2));

endmodule

// File: rtl/ds_credit_ctr.sv
module ds_credit_ctr #(
    parameter int STEP = 8,
    parameter int MAX  = 56
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            add,
    input  logic                            take,
    output logic [$clog2(MAX+STEP+1)-1:0]   credit,
    output logic                            err
);
    localparam int CW = $clog2(MAX + STEP + 1);

    logic [CW:0] base;
    logic [CW:0] sum;

    always_comb begin
        base = {1'b0, credit} - {{CW{1'b0}}, take};
        sum  = base + (CW+1)'(STEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit <= '0;
            err    <= 1'b0;
        end else if (add && (sum > (CW+1)'(MAX))) begin
            credit <= base[CW-1:0];
            err    <= 1'b1;
        end else if (add) begin
            credit <= sum[CW-1:0];
        end else begin
            credit <= base[CW-1:0];
        end
    end

    // R11: the balance never passes its ceiling
    a_r11_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= CW'(MAX));

endmodule

// File: rtl/ds_line_drv.sv
module ds_line_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic emit,
    input  logic bit_in,
    output logic d_q,
    output logic s_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= 1'b0;
            s_q <= 1'b0;
        end else if (emit) begin
            d_q <= bit_in;
            if (bit_in == d_q) begin
                s_q <= ~s_q;
            end
        end
    end

    // R2: never both lines in one clock
    a_r2_one_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({d_q ^ $past(d_q), s_q ^ $past(s_q)}) <= 1));

endmodule

// File: rtl/ds_char_tx.sv
module ds_char_tx
    import ds_tx_pkg::*;
#(
    parameter int CREDIT_STEP = 8,
    parameter int CREDIT_MAX  = 56
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_null,
    input  logic       en_fct,
    input  logic       en_data,
    input  logic       en_time,
    input  logic       fifo_empty,
    input  logic [8:0] fifo_dout,
    output logic       fifo_rd,
    input  logic       tick_in,
    input  logic [5:0] time_in,
    input  logic [1:0] flags_in,
    input  logic       fct_send,
    input  logic       fct_req,
    output logic       fct_ack,
    output logic       d_out,
    output logic       s_out,
    output logic       credit_err
);
    localparam int CW  = $clog2(CREDIT_MAX + CREDIT_STEP + 1);
    localparam int SHW = CTRL_LEN + DATA_LEN;
    localparam int LW  = $clog2(SHW + 1);

    tx_state_t        state_q, state_nx;
    logic [SHW-1:0]   sh_q, sh_nx;
    logic [LW-1:0]    left_q, len_nx;
    logic             prev_q, prev_nx;
    logic             tc_pend_q, fct_pend_q, hold_v_q;
    logic [7:0]       tc_val_q;
    logic [8:0]       hold_q;
    logic [CW-1:0]    credit;
    logic             fct_evt;
    logic             choose, ld, take;
    pick_t            pick;
    logic [3:0]       esc_c, ctl_c, fct_c;
    logic [9:0]       dat_c;

    ds_fct_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (fct_req),
        .ack       (fct_ack),
        .evt       (fct_evt)
    );

    ds_credit_ctr #(.STEP(CREDIT_STEP), .MAX(CREDIT_MAX)) u_credit (
        .clk    (clk),
        .rst_n  (rst_n),
        .add    (fct_evt),
        .take   (take),
        .credit (credit),
        .err    (credit_err)
    );

    ds_line_drv u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .emit   (state_q == ST_SEND),
        .bit_in (sh_q[0]),
        .d_q    (d_out),
        .s_q    (s_out)
    );

    assign fifo_rd = !hold_v_q && !fifo_empty;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // selection, character building and next state
    always_comb begin
        choose  = (state_q == ST_IDLE) || (left_q == LW'(1));
        pick    = PICK_NONE;
        if (choose) begin
            if (tc_pend_q && en_time)                          pick = PICK_TIME;
            else if (fct_pend_q && en_fct)                     pick = PICK_FCT;
            else if (hold_v_q && en_data && credit != '0)      pick = PICK_DATA;
            else if (en_null)                                  pick = PICK_NULL;
        end
        ld   = (pick != PICK_NONE);
        take = (pick == PICK_DATA);

        esc_c = ctrl_char(prev_q, CC_ESC);
        fct_c = ctrl_char(prev_q, CC_FCT);
        ctl_c = ctrl_char(prev_q, hold_q[0] ? CC_EEP : CC_EOP);
        dat_c = data_char(prev_q, hold_q[7:0]);

        sh_nx   = '0;
        len_nx  = '0;
        prev_nx = prev_q;
        unique case (pick)
            PICK_TIME: begin
                sh_nx   = {data_char(1'b0, tc_val_q), esc_c};
                len_nx  = LW'(CTRL_LEN + DATA_LEN);
                prev_nx = ^tc_val_q;
            end
            PICK_FCT: begin
                sh_nx   = SHW'(fct_c);
                len_nx  = LW'(CTRL_LEN);
                prev_nx = 1'b0;
            end
            PICK_DATA: begin
                if (hold_q[8]) begin
                    sh_nx   = SHW'(ctl_c);
                    len_nx  = LW'(CTRL_LEN);
                    prev_nx = 1'b1;
                end else begin
                    sh_nx   = SHW'(dat_c);
                    len_nx  = LW'(DATA_LEN);
                    prev_nx = ^hold_q[7:0];
                end
            end
            PICK_NULL: begin
                sh_nx   = SHW'({ctrl_char(1'b0, CC_FCT), esc_c});
                len_nx  = LW'(2 * CTRL_LEN);
                prev_nx = 1'b0;
            end
            default: ;
        endcase

        unique case (state_q)
            ST_IDLE: state_nx = ld ? ST_SEND : ST_IDLE;
            ST_SEND: state_nx = (choose && !ld) ? ST_IDLE : ST_SEND;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q       <= '0;
            left_q     <= '0;
            prev_q     <= 1'b0;
            tc_pend_q  <= 1'b0;
            tc_val_q   <= '0;
            fct_pend_q <= 1'b0;
            hold_v_q   <= 1'b0;
            hold_q     <= '0;
        end else begin
            if (ld) begin
                sh_q   <= sh_nx;
                left_q <= len_nx;
                prev_q <= prev_nx;
            end else if (state_q == ST_SEND) begin
                sh_q   <= sh_q >> 1;
                left_q <= left_q - LW'(1);
            end

            if (tick_in) begin
                tc_pend_q <= 1'b1;
                tc_val_q  <= {flags_in, time_in};
            end else if (pick == PICK_TIME) begin
                tc_pend_q <= 1'b0;
            end

            if (fct_send)                fct_pend_q <= 1'b1;
            else if (pick == PICK_FCT)   fct_pend_q <= 1'b0;

            if (fifo_rd) begin
                hold_v_q <= 1'b1;
                hold_q   <= fifo_dout;
            end else if (take) begin
                hold_v_q <= 1'b0;
            end
        end
    end

    // R9: one credit leaves with each FIFO entry sent
    a_r9_take_costs_one: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !fct_evt) |=> (credit == $past(credit) - CW'(1)));

    // R9: a popped entry is held until it is sent
    a_r9_prefetch_held: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> hold_v_q);

    // R11: the error appears only after an arriving FCT
    a_r11_err_on_add: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(credit_err) |-> $past(fct_evt));

endmodule

// File: tb/ds_char_tx_test.sv
module ds_char_tx_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_null = 0, en_fct = 0, en_data = 0, en_time = 0;
    logic fifo_empty, fifo_rd;
    logic [8:0] fifo_dout;
    logic tick_in = 0;
    logic [5:0] time_in = 0;
    logic [1:0] flags_in = 0;
    logic fct_send = 0, fct_req = 0, fct_ack;
    logic d_out, s_out, credit_err;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ds_char_tx uut (
        .clk(clk), .rst_n(rst_n), .en_null(en_null), .en_fct(en_fct),
        .en_data(en_data), .en_time(en_time), .fifo_empty(fifo_empty),
        .fifo_dout(fifo_dout), .fifo_rd(fifo_rd), .tick_in(tick_in),
        .time_in(time_in), .flags_in(flags_in), .fct_send(fct_send),
        .fct_req(fct_req), .fct_ack(fct_ack), .d_out(d_out), .s_out(s_out),
        .credit_err(credit_err)
    );

    // transmit FIFO model, first word visible while not empty
    logic [8:0] fmem [0:511];
    int wp = 0, rp = 0;
    assign fifo_empty = (wp == rp);
    assign fifo_dout  = fmem[rp[8:0]];
    always @(posedge clk) begin
        if (!rst_n) rp <= wp;
        else if (fifo_rd) rp <= rp + 1;
    end

    // line decoder
    logic pd, ps, pbit, flagb, px, esc, bit_b;
    int ph, need, cnt;
    logic [7:0] acc;
    int nrec, null_cnt, par_err, tog_err, nbits;
    int rec_kind [0:1023];
    int rec_val  [0:1023];

    always @(negedge clk) begin
        if (!rst_n) begin
            pd = 0; ps = 0; ph = 0; cnt = 0; acc = 0; px = 0; esc = 0;
            nrec = 0; null_cnt = 0; par_err = 0; tog_err = 0; nbits = 0;
        end else begin
            if ((d_out != pd) && (s_out != ps)) tog_err++;
            else if ((d_out != pd) || (s_out != ps)) begin
                nbits++;
                bit_b = d_out;
                if (ph == 0) begin
                    pbit = bit_b; ph = 1;
                end else if (ph == 1) begin
                    if ((px ^ pbit ^ bit_b) != 1'b1) par_err++;
                    flagb = bit_b; need = bit_b ? 2 : 8; cnt = 0; acc = 0; ph = 2;
                end else begin
                    acc[cnt] = bit_b;
                    cnt++;
                    if (cnt == need) begin
                        px = ^acc;
                        ph = 0;
                        if (flagb) begin
                            if (acc[1:0] == 2'd3) esc = 1;
                            else if (esc && acc[1:0] == 2'd0) begin null_cnt++; esc = 0; end
                            else begin
                                rec_kind[nrec] = 1; rec_val[nrec] = int'(acc[1:0]); nrec++; esc = 0;
                            end
                        end else begin
                            rec_kind[nrec] = esc ? 2 : 0; rec_val[nrec] = int'(acc); nrec++; esc = 0;
                        end
                    end
                end
            end
            pd = d_out; ps = s_out;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; en_null = 0; en_fct = 0; en_data = 0; en_time = 0;
        fct_req = 0; fct_send = 0; tick_in = 0;
        cycles(3);
        rst_n = 1;
        cycles(1);
    endtask

    task automatic push(input logic [8:0] v);
        fmem[wp[8:0]] = v;
        wp++;
    endtask

    // R10: four-phase handshake with ack timing checks
    task automatic give_fct();
        fct_req = 1;
        @(negedge clk); chk(fct_ack == 0, "R10 ack early", fct_ack, 0);
        @(negedge clk); chk(fct_ack == 1, "R10 ack rise", fct_ack, 1);
        fct_req = 0;
        @(negedge clk); chk(fct_ack == 1, "R10 ack hold", fct_ack, 1);
        @(negedge clk); chk(fct_ack == 0, "R10 ack fall", fct_ack, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        int base, n, start, b0;
        // R1 reset state
        cycles(2);
        chk(d_out == 0 && s_out == 0, "R1 lines in reset", {d_out, s_out}, 0);
        chk(credit_err == 0 && fct_ack == 0, "R1 flags in reset", {credit_err, fct_ack}, 0);
        do_reset();
        chk(d_out == 0 && s_out == 0, "R1 lines after reset", {d_out, s_out}, 0);

        // R12 idle holds the lines
        cycles(50);
        chk(nbits == 0, "R12 idle bits", nbits, 0);
        chk(d_out == 0 && s_out == 0, "R12 idle level", {d_out, s_out}, 0);

        // R5 NULL stream, R2 back-to-back bits, R4 parity
        en_null = 1;
        cycles(20);
        b0 = nbits;
        cycles(100);
        chk(nbits - b0 == 100, "R2 one bit per clock", nbits - b0, 100);
        chk(nrec == 0, "R5 only NULLs", nrec, 0);
        chk(null_cnt >= 14, "R5 NULL count", null_cnt, 14);
        chk(tog_err == 0, "R2 single toggle", tog_err, 0);
        chk(par_err == 0, "R4 parity NULL", par_err, 0);

        // R9 no data without credit
        en_data = 1;
        for (int i = 0; i < 5; i++) push(9'(8'h10 + i));
        cycles(100);
        chk(nrec == 0, "R9 zero credit blocks data", nrec, 0);

        // R9/R10 one FCT gives eight characters
        for (int i = 5; i < 10; i++) push(9'(8'h10 + i));
        give_fct();
        cycles(200);
        chk(nrec == 8, "R10 eight credits", nrec, 8);
        for (int i = 0; i < 8; i++)
            chk(rec_kind[i] == 0 && rec_val[i] == 'h10 + i, "R9 data order", rec_val[i], 'h10 + i);

        // R3/R9 sweep of all byte values in credit batches
        do_reset();
        en_null = 1; en_data = 1;
        for (base = 0; base < 256; base += 56) begin
            n = (256 - base < 56) ? 256 - base : 56;
            start = nrec;
            for (int i = 0; i < n; i++) push(9'(base + i));
            for (int k = 0; k < n / 8; k++) give_fct();
            cycles(n * 10 + 100);
            chk(nrec == start + n, "R9 batch count", nrec - start, n);
            for (int i = 0; i < n; i++)
                chk(rec_kind[start+i] == 0 && rec_val[start+i] == base + i,
                    "R3 data value", rec_val[start+i], base + i);
        end
        chk(par_err == 0, "R4 parity data sweep", par_err, 0);

        // R9 end-of-packet markers
        start = nrec;
        push(9'h100); push(9'h1FF);
        give_fct();
        cycles(60);
        chk(nrec == start + 2, "R9 marker count", nrec - start, 2);
        chk(rec_kind[start] == 1 && rec_val[start] == 1, "R9 EOP code", rec_val[start], 1);
        chk(rec_kind[start+1] == 1 && rec_val[start+1] == 2, "R9 EEP code", rec_val[start+1], 2);
        chk(par_err == 0, "R4 parity markers", par_err, 0);

        // R6 time-code sweep
        do_reset();
        en_null = 1; en_time = 1;
        for (int t = 0; t < 64; t++) begin
            start = nrec;
            time_in = 6'(t); flags_in = 2'(t ^ (t >> 2));
            tick_in = 1; @(negedge clk); tick_in = 0;
            cycles(30);
            chk(nrec == start + 1 && rec_kind[start] == 2 &&
                rec_val[start] == ((((t ^ (t >> 2)) & 3) << 6) | t),
                "R6 time code", rec_val[start], (((t ^ (t >> 2)) & 3) << 6) | t);
        end
        chk(par_err == 0, "R4 parity time codes", par_err, 0);

        // R6 time code waits for its enable
        en_time = 0; start = nrec;
        time_in = 6'h15; flags_in = 2'b10;
        tick_in = 1; @(negedge clk); tick_in = 0;
        cycles(60);
        chk(nrec == start, "R6 held while disabled", nrec - start, 0);
        en_time = 1;
        cycles(30);
        chk(nrec == start + 1 && rec_val[start] == 'h95, "R6 sent when enabled", rec_val[start], 'h95);

        // R7 lone FCT
        start = nrec; en_fct = 1;
        fct_send = 1; @(negedge clk); fct_send = 0;
        cycles(30);
        chk(nrec == start + 1 && rec_kind[start] == 1 && rec_val[start] == 0,
            "R7 FCT sent", rec_val[start], 0);

        // R8 time code, FCT and data raised together
        do_reset();
        en_null = 1; en_fct = 1; en_data = 1; en_time = 1;
        give_fct();
        cycles(10);
        push(9'h0A5);
        time_in = 6'h2A; flags_in = 2'b01;
        fct_send = 1; tick_in = 1; @(negedge clk); fct_send = 0; tick_in = 0;
        cycles(80);
        chk(nrec == 3, "R8 three characters", nrec, 3);
        chk(rec_kind[0] == 2 && rec_val[0] == 'h6A, "R8 time first", rec_kind[0], 2);
        chk(rec_kind[1] == 1 && rec_val[1] == 0, "R8 FCT second", rec_kind[1], 1);
        chk(rec_kind[2] == 0 && rec_val[2] == 'hA5, "R8 data third", rec_val[2], 'hA5);

        // R11 credit ceiling
        do_reset();
        for (int k = 0; k < 7; k++) give_fct();
        cycles(3);
        chk(credit_err == 0, "R11 56 credits accepted", credit_err, 0);
        give_fct();
        cycles(3);
        chk(credit_err == 1, "R11 overflow flagged", credit_err, 1);
        for (int i = 0; i < 60; i++) push(9'(i));
        en_data = 1;
        cycles(800);
        chk(nrec == 56, "R11 credit unchanged", nrec, 56);
        chk(credit_err == 1, "R11 flag sticky", credit_err, 1);
        chk(tog_err == 0, "R2 single toggle overall", tog_err, 0);

        summary();
    end
endmodule